// File: doc/BRIEF.md
# I2C Master Read Sequencer

This block runs the controller side of an I2C read. A host starts a transfer and gives the target address, a flag that selects 7-bit or 10-bit addressing, a byte count and an acknowledge enable. The block then produces the Start condition, the address or header bytes, the Repeated Start that 10-bit reads need, the clocked data bytes and the closing Stop. SCL is made from a divider that splits each bit into four quarter-phases. Both lines are open-drain: the block only ever pulls a line low or lets it go.

The host follows the transfer through sticky event flags. The flags show that a Start went out, that the address phase was accepted, that the first 10-bit header was accepted, that a byte arrived, and that an address byte was refused. Each flag is cleared by its own one-cycle pulse. At every flag except byte-received the sequencer holds SCL low until the host answers. After a Stop it returns to idle without any host action.

For a 10-bit read the address goes out in two parts. The first part is the header with the write direction, then the low eight address bits. After that comes a Repeated Start and the header again with the read direction, and then the data.

Top module: `i2c_rd_master`

## Requirements
- R1: After reset the block is idle. `busy` is 0, neither line is pulled low, and every event flag is 0.
- R2: In a 7-bit read with `ack_en`=1 and count N, the bus carries, in order: Start, the byte {addr[6:0],1}, an ACK from the target, and N data bytes. The block ACKs (SDA low) each data byte except the last, NACKs (SDA high) the last, and then sends Stop.
- R3: In a 10-bit read the bus carries, in order: Start, the header {11110,addr[9:8],0}, ACK, addr[7:0], ACK, Repeated Start, the header {11110,addr[9:8],1}, ACK, then the data bytes and the closing NACK and Stop exactly as in R2.
- R4: `ev_start` rises after each Start and each Repeated Start. While it waits, the block keeps SCL low until `ack_start` is pulsed. That pulse clears the flag and sends the next address or header byte.
- R5: `ev_addr` rises when the target ACKs the last byte of an address phase: the 7-bit address, the low address byte, or the read header. The block then waits for `ack_addr`, which clears the flag. After the low address byte this pulse starts the Repeated Start. Otherwise it starts data reception.
- R6: In 10-bit mode `ev_hdr` rises when the first header is ACKed. The block waits, with SCL held low, for `ack_hdr`. That pulse clears the flag and sends addr[7:0].
- R7: After each data byte's acknowledge bit, `ev_rx` rises and `rx_data` holds the received byte, most significant bit first. A `rd_ack` pulse clears `ev_rx`.
- R8: With `ack_en`=0 the first data byte is NACKed and a Stop follows at once, whatever the count.
- R9: `busy` is 1 in the cycle after an accepted `cmd_start`. It returns to 0 on its own once the Stop has been sent, and both lines are released at that point.
- R10: SDA driven by the block changes only while SCL is low, except while it forms a Start, Repeated Start or Stop. Incoming data and acknowledge bits are sampled as SCL rises.
- R11: A NACK on any address or header byte sets `err_nack`. The block then holds SCL low until `cmd_stop` is pulsed, sends a Stop and goes idle. The next accepted `cmd_start` clears `err_nack`.
- R12: A `cmd_start` pulse while `busy` is 1 has no effect on the bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: begin a read (ignored while busy) |
| cmd_stop | input | 1 | Pulse: send Stop after an address NACK |
| tgt_addr | input | 10 | Target address; bits [6:0] are used in 7-bit mode |
| addr_10b | input | 1 | 1 selects 10-bit addressing |
| rd_count | input | CNT_W | Number of bytes to read (0 is treated as 1) |
| ack_en | input | 1 | 1 lets the block ACK received bytes other than the last |
| ack_start | input | 1 | Pulse: clear `ev_start` and send the next byte |
| ack_addr | input | 1 | Pulse: clear `ev_addr` and continue |
| ack_hdr | input | 1 | Pulse: clear `ev_hdr` and send the low address byte |
| rd_ack | input | 1 | Pulse: clear `ev_rx` |
| ev_start | output | 1 | Start or Repeated Start sent |
| ev_addr | output | 1 | Address phase acknowledged |
| ev_hdr | output | 1 | First 10-bit header acknowledged |
| ev_rx | output | 1 | Data byte received |
| err_nack | output | 1 | Address or header byte was not acknowledged |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | A transfer is in progress |
| scl_low | output | 1 | 1 pulls SCL low |
| sda_low | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Level of the SDA line |

## Verification
Flag clears and `busy` are registered outputs, so the bench samples them at the falling edge that follows the rising edge which took the host pulse, one cycle after the stimulus. Bus activity only moves on quarter-phase ticks, every QDIV clocks, so the time until a flag rises depends on the divider. For that reason the bench polls each flag at falling edges with a bounded wait rather than at a fixed cycle. A behavioural target on the bench's pull-up lines decodes Start, Stop and every 9-bit byte on each clock. It compares each decoded event, as soon as it appears, against a queue built from the requirements. Hold behaviour is checked by idling a set number of cycles while a flag is pending and then confirming that SCL is still low and the flag is still set.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT_SB,
        ST_TX,
        ST_WAIT_HDR,
        ST_WAIT_ADDR,
        ST_RX,
        ST_STOP,
        ST_WAIT_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_LOW,
        PH_READ
    } addr_phase_e;

    localparam int NUM_FLAGS = 5;
    localparam int FL_SB     = 0;
    localparam int FL_ADDR   = 1;
    localparam int FL_HDR    = 2;
    localparam int FL_RX     = 3;
    localparam int FL_AF     = 4;

    localparam logic [4:0] HDR_MARK = 5'b11110;

endpackage

// File: rtl/i2c_rd_qtick.sv
module i2c_rd_qtick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_rd_flags.sv
module i2c_rd_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] fl_d, fl_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // a set in the same cycle as a clear wins
        assign fl_d[i] = set_i[i] | (fl_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flag_o = fl_q;
endmodule

// File: rtl/i2c_rd_master.sv
module i2c_rd_master
    import i2c_rd_pkg::*;
#(
    parameter int QDIV  = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic [9:0]       tgt_addr,
    input  logic             addr_10b,
    input  logic [CNT_W-1:0] rd_count,
    input  logic             ack_en,
    input  logic             ack_start,
    input  logic             ack_addr,
    input  logic             ack_hdr,
    input  logic             rd_ack,
    output logic             ev_start,
    output logic             ev_addr,
    output logic             ev_hdr,
    output logic             ev_rx,
    output logic             err_nack,
    output logic [7:0]       rx_data,
    output logic             busy,
    output logic             scl_low,
    output logic             sda_low,
    input  logic             sda_in
);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    typedef struct packed {
        seq_state_e       st;
        addr_phase_e      ph;
        logic [1:0]       qtr;
        logic [3:0]       bitn;
        logic [7:0]       sh;
        logic [CNT_W-1:0] left;
        logic             scl;
        logic             sda;
        logic [7:0]       rxd;
        logic             a10;
        logic [9:0]       addr;
        logic             acken;
    } ctx_t;

    ctx_t                 q, d;
    logic                 tick;
    logic [NUM_FLAGS-1:0] fset, fclr, flag_w;
    logic                 last_byte, mack_low;
    seq_state_e           st_w;

    i2c_rd_qtick #(.QDIV(QDIV)) u_qtick (
        .clk(clk), .rst_n(rst_n), .run(q.st != ST_IDLE), .tick(tick)
    );

    i2c_rd_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(fset), .clr_i(fclr), .flag_o(flag_w)
    );

    assign last_byte = (q.left == CNT_W'(1));
    assign mack_low  = q.acken & ~last_byte;

    always_comb begin
        d    = q;
        fset = '0;
        fclr = '0;
        fclr[FL_SB]   = ack_start;
        fclr[FL_ADDR] = ack_addr;
        fclr[FL_HDR]  = ack_hdr;
        fclr[FL_RX]   = rd_ack;
        fclr[FL_AF]   = cmd_start & (q.st == ST_IDLE);

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    d.st    = ST_START;
                    d.ph    = PH_FIRST;
                    d.qtr   = '0;
                    d.addr  = tgt_addr;
                    d.a10   = addr_10b;
                    d.acken = ack_en;
                    d.left  = (rd_count == '0) ? CNT_W'(1) : rd_count;
                end
            end
            ST_START: if (tick) begin
                d.qtr = q.qtr + 2'd1;
                unique case (q.qtr)
                    2'd0: d.sda = 1'b1;
                    2'd1: d.scl = 1'b1;
                    2'd2: d.sda = 1'b0;
                    default: begin
                        d.scl = 1'b0;
                        d.st  = ST_WAIT_SB;
                        fset[FL_SB] = 1'b1;
                    end
                endcase
            end
            ST_WAIT_SB: if (ack_start) begin
                d.st   = ST_TX;
                d.qtr  = '0;
                d.bitn = '0;
                if (q.ph == PH_READ)  d.sh = {HDR_MARK, q.addr[9:8], 1'b1};
                else if (q.a10)       d.sh = {HDR_MARK, q.addr[9:8], 1'b0};
                else                  d.sh = {q.addr[6:0], 1'b1};
            end
            ST_TX: if (tick) begin
                d.qtr = q.qtr + 2'd1;
                unique case (q.qtr)
                    2'd0: d.sda = (q.bitn == ACK_SLOT) ? 1'b1 : q.sh[7];
                    2'd1: begin
                        d.scl = 1'b1;
                        if (q.bitn == ACK_SLOT) d.sh[0] = sda_in;
                    end
                    2'd2: ;
                    default: begin
                        d.scl = 1'b0;
                        if (q.bitn != ACK_SLOT) begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.bitn = q.bitn + 4'd1;
                        end else if (q.sh[0]) begin
                            d.st = ST_WAIT_STOP;
                            fset[FL_AF] = 1'b1;
                        end else if (q.a10 && q.ph == PH_FIRST) begin
                            d.st = ST_WAIT_HDR;
                            fset[FL_HDR] = 1'b1;
                        end else begin
                            d.st = ST_WAIT_ADDR;
                            fset[FL_ADDR] = 1'b1;
                        end
                    end
                endcase
            end
            ST_WAIT_HDR: if (ack_hdr) begin
                d.st   = ST_TX;
                d.ph   = PH_LOW;
                d.qtr  = '0;
                d.bitn = '0;
                d.sh   = q.addr[7:0];
            end
            ST_WAIT_ADDR: if (ack_addr) begin
                d.qtr  = '0;
                d.bitn = '0;
                if (q.a10 && q.ph == PH_LOW) begin
                    d.st = ST_START;
                    d.ph = PH_READ;
                end else begin
                    d.st = ST_RX;
                end
            end
            ST_RX: if (tick) begin
                d.qtr = q.qtr + 2'd1;
                unique case (q.qtr)
                    2'd0: d.sda = (q.bitn == ACK_SLOT) ? ~mack_low : 1'b1;
                    2'd1: begin
                        d.scl = 1'b1;
                        if (q.bitn != ACK_SLOT) d.sh = {q.sh[6:0], sda_in};
                    end
                    2'd2: ;
                    default: begin
                        d.scl = 1'b0;
                        if (q.bitn != ACK_SLOT) begin
                            d.bitn = q.bitn + 4'd1;
                        end else begin
                            d.rxd = q.sh;
                            fset[FL_RX] = 1'b1;
                            d.bitn = '0;
                            if (mack_low) d.left = q.left - CNT_W'(1);
                            else          d.st   = ST_STOP;
                        end
                    end
                endcase
            end
            ST_STOP: if (tick) begin
                d.qtr = q.qtr + 2'd1;
                unique case (q.qtr)
                    2'd0: d.sda = 1'b0;
                    2'd1: d.scl = 1'b1;
                    2'd2: d.sda = 1'b1;
                    default: d.st = ST_IDLE;
                endcase
            end
            ST_WAIT_STOP: if (cmd_stop) begin
                d.st  = ST_STOP;
                d.qtr = '0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ph    <= PH_FIRST;
            q.scl   <= 1'b1;
            q.sda   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign st_w     = q.st;
    assign busy     = (q.st != ST_IDLE);
    assign scl_low  = ~q.scl;
    assign sda_low  = ~q.sda;
    assign rx_data  = q.rxd;
    assign ev_start = flag_w[FL_SB];
    assign ev_addr  = flag_w[FL_ADDR];
    assign ev_hdr   = flag_w[FL_HDR];
    assign ev_rx    = flag_w[FL_RX];
    assign err_nack = flag_w[FL_AF];
endmodule

// File: rtl/i2c_rd_master_chk.sv
module i2c_rd_master_chk
    import i2c_rd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input seq_state_e           st,
    input logic                 scl_low,
    input logic                 sda_low,
    input logic                 busy,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 ack_start,
    input logic                 cmd_stop
);
    AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
        |-> (st == ST_START || st == ST_STOP)); // R10

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!scl_low && !sda_low)); // R9

    AST_ONE_ADDR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags[FL_SB], flags[FL_ADDR], flags[FL_HDR], flags[FL_AF]})); // R5

    AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_SB && !ack_start) |=> (st == ST_WAIT_SB && scl_low && flags[FL_SB])); // R4

    AST_NACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_STOP && !cmd_stop) |=> (st == ST_WAIT_STOP && scl_low && flags[FL_AF])); // R11

    AST_BUSY_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(st) == ST_STOP)); // R9
endmodule

bind i2c_rd_master i2c_rd_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_w), .scl_low(scl_low), .sda_low(sda_low),
    .busy(busy), .flags(flag_w), .ack_start(ack_start), .cmd_stop(cmd_stop)
);

// File: tb/i2c_rd_master_bench.sv
module i2c_rd_master_bench;
    localparam int QDIV  = 4;
    localparam int CNT_W = 8;
    localparam int EV_S  = 1000;
    localparam int EV_P  = 1001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic cmd_start = 0, cmd_stop = 0, addr_10b = 0, ack_en = 0;
    logic ack_start = 0, ack_addr = 0, ack_hdr = 0, rd_ack = 0;
    logic [9:0] tgt_addr = '0;
    logic [CNT_W-1:0] rd_count = '0;
    logic ev_start, ev_addr, ev_hdr, ev_rx, err_nack, busy, scl_low, sda_low;
    logic [7:0] rx_data;

    logic sl_drv = 1'b0;
    wire  scl_line = ~scl_low;
    wire  sda_line = ~(sda_low | sl_drv);
    wire [4:0] flag_bus = {err_nack, ev_rx, ev_hdr, ev_addr, ev_start};

    i2c_rd_master #(.QDIV(QDIV), .CNT_W(CNT_W)) u_i2c_rd_master (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .tgt_addr(tgt_addr), .addr_10b(addr_10b), .rd_count(rd_count), .ack_en(ack_en),
        .ack_start(ack_start), .ack_addr(ack_addr), .ack_hdr(ack_hdr), .rd_ack(rd_ack),
        .ev_start(ev_start), .ev_addr(ev_addr), .ev_hdr(ev_hdr), .ev_rx(ev_rx),
        .err_nack(err_nack), .rx_data(rx_data), .busy(busy),
        .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_line)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_tag = "R1";
    int    exp_q[$];
    logic [7:0] sl_data[$];
    logic [7:0] rx_exp[$];

    task automatic chk(input bit ok, input string what, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_tag, what, act, expv);
        end
    endtask

    task automatic ev_seen(input int code);
        int e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "unexpected bus event", code, -1);
        end else begin
            e = exp_q.pop_front();
            chk(code == e, "bus event (R10 ordering)", code, e);
        end
    endtask

    // behavioural target plus bus decoder
    logic scl_p = 1'b1, sda_p = 1'b1;
    int   sl_mode = 0, bitn = 0;
    bit   first = 0, mack = 0, sl_nack_addr = 0;
    logic [7:0] rsh = '0, tx_cur = '0;

    always @(negedge clk) begin
        logic s, a;
        s = scl_line;
        a = sda_line;
        if (rst_n) begin
            if (s && scl_p && sda_p && !a) begin
                ev_seen(EV_S);
                sl_mode = 1; bitn = 0; first = 1; sl_drv = 1'b0;
            end else if (s && scl_p && !sda_p && a) begin
                ev_seen(EV_P);
                sl_mode = 0; sl_drv = 1'b0;
            end else if (s && !scl_p) begin
                if (sl_mode == 1) begin
                    if (bitn < 8) begin rsh = {rsh[6:0], a}; bitn++; end
                    else if (bitn == 8) begin ev_seen(int'(rsh) | (int'(a) << 8)); bitn = 9; end
                end else if (sl_mode == 2) begin
                    if (bitn < 8) bitn++;
                    else if (bitn == 8) begin ev_seen(int'(tx_cur) | (int'(a) << 8)); mack = a; bitn = 9; end
                end
            end else if (!s && scl_p) begin
                if (sl_mode == 1) begin
                    if (bitn == 8) sl_drv = !sl_nack_addr;
                    else if (bitn == 9) begin
                        sl_drv = 1'b0;
                        bitn = 0;
                        if (first && rsh[0] && !sl_nack_addr) begin
                            sl_mode = 2;
                            tx_cur = (sl_data.size() > 0) ? sl_data.pop_front() : 8'hFF;
                            sl_drv = !tx_cur[7];
                        end
                        first = 0;
                    end
                end else if (sl_mode == 2) begin
                    if (bitn >= 1 && bitn <= 7) sl_drv = !tx_cur[7 - bitn];
                    else if (bitn == 8) sl_drv = 1'b0;
                    else if (bitn == 9) begin
                        if (!mack) begin
                            tx_cur = (sl_data.size() > 0) ? sl_data.pop_front() : 8'hFF;
                            bitn = 0;
                            sl_drv = !tx_cur[7];
                        end else begin
                            sl_drv = 1'b0;
                            sl_mode = 0;
                        end
                    end
                end
            end
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: cmd_start = 1'b1;
            1: cmd_stop  = 1'b1;
            2: ack_start = 1'b1;
            3: ack_addr  = 1'b1;
            4: ack_hdr   = 1'b1;
            default: rd_ack = 1'b1;
        endcase
        @(negedge clk);
        cmd_start = 0; cmd_stop = 0; ack_start = 0; ack_addr = 0; ack_hdr = 0; rd_ack = 0;
    endtask

    task automatic wait_flag(input int idx, input string what);
        int k;
        k = 0;
        while (flag_bus[idx] !== 1'b1 && k < 4000) begin @(negedge clk); k++; end
        chk(k < 4000, what, flag_bus[idx], 1);
    endtask

    task automatic ack_flag(input int idx, input int which, input string what);
        pulse(which);
        chk(flag_bus[idx] == 1'b0, what, flag_bus[idx], 0);
    endtask

    task automatic wait_idle();
        int k;
        k = 0;
        while (busy && k < 8000) begin @(negedge clk); k++; end
        chk(busy == 1'b0, "busy clears by itself after Stop (R9)", busy, 0);
        chk(!scl_low && !sda_low, "lines released at idle (R9)", {scl_low, sda_low}, 0);
        chk(exp_q.size() == 0, "all expected bus events seen", exp_q.size(), 0);
    endtask

    task automatic run_read(input bit a10, input logic [9:0] adr, input int n,
                            input bit aen, input bit nack_adr, input bit poke_start);
        int nb;
        logic [7:0] b0;
        nb = aen ? n : 1;
        exp_q.delete(); sl_data.delete(); rx_exp.delete();
        sl_nack_addr = nack_adr;
        b0 = a10 ? {5'b11110, adr[9:8], 1'b0} : {adr[6:0], 1'b1};
        exp_q.push_back(EV_S);
        if (nack_adr) begin
            exp_q.push_back(int'(b0) | 256);
            exp_q.push_back(EV_P);
        end else begin
            exp_q.push_back(int'(b0));
            if (a10) begin
                exp_q.push_back(int'(adr[7:0]));
                exp_q.push_back(EV_S);
                exp_q.push_back(int'({5'b11110, adr[9:8], 1'b1}));
            end
            for (int i = 0; i < nb; i++) begin
                logic [7:0] dv;
                dv = 8'(8'h3C + i * 8'h51);
                sl_data.push_back(dv);
                rx_exp.push_back(dv);
                exp_q.push_back(int'(dv) | (((aen && i < nb - 1) ? 0 : 1) << 8));
            end
            exp_q.push_back(EV_P);
        end
        tgt_addr = adr; addr_10b = a10; rd_count = CNT_W'(n); ack_en = aen;
        pulse(0);
        chk(busy == 1'b1, "busy one cycle after cmd_start (R9)", busy, 1);
        if (nack_adr == 0) chk(err_nack == 1'b0, "err cleared by new start (R11)", err_nack, 0);

        wait_flag(0, "start flag raised (R4)");
        repeat (5 * QDIV) @(negedge clk);
        chk(ev_start && scl_low, "SCL held low while start flag pending (R4)", {ev_start, scl_low}, 3);
        ack_flag(0, 2, "ack_start clears start flag (R4)");
        if (poke_start) begin
            pulse(0); // R12: ignored while busy; the event queue would catch an extra Start
            chk(busy == 1'b1, "cmd_start while busy leaves transfer running (R12)", busy, 1);
        end

        if (nack_adr) begin
            wait_flag(4, "address NACK sets err_nack (R11)");
            repeat (6 * QDIV) @(negedge clk);
            chk(scl_low && busy && err_nack, "held until cmd_stop (R11)", {scl_low, busy, err_nack}, 7);
            pulse(1);
            wait_idle();
            return;
        end

        if (a10) begin
            wait_flag(2, "header flag raised (R6)");
            repeat (5 * QDIV) @(negedge clk);
            chk(ev_hdr && scl_low, "SCL held low while header flag pending (R6)", {ev_hdr, scl_low}, 3);
            ack_flag(2, 4, "ack_hdr clears header flag (R6)");
            wait_flag(1, "addr flag after low byte (R5)");
            ack_flag(1, 3, "ack_addr clears addr flag (R5)");
            wait_flag(0, "start flag after Repeated Start (R3)");
            ack_flag(0, 2, "ack_start clears start flag again (R4)");
        end
        wait_flag(1, "addr flag before data (R5)");
        ack_flag(1, 3, "ack_addr clears addr flag (R5)");

        for (int i = 0; i < nb; i++) begin
            wait_flag(3, "byte-received flag (R7)");
            chk(rx_data == rx_exp[i], "rx_data sampled on SCL rise (R7 R10)", rx_data, rx_exp[i]);
            ack_flag(3, 5, "rd_ack clears byte flag (R7)");
        end
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cur_tag = "R1";
        chk(busy == 1'b0, "reset busy", busy, 0);
        chk(!scl_low && !sda_low, "reset lines released", {scl_low, sda_low}, 0);
        chk(flag_bus == 5'd0, "reset flags", flag_bus, 0);

        cur_tag = "R2";
        run_read(1'b0, 10'h052, 3, 1'b1, 1'b0, 1'b1);
        cur_tag = "R3";
        run_read(1'b1, 10'h2C7, 2, 1'b1, 1'b0, 1'b0);
        cur_tag = "R8";
        run_read(1'b0, 10'h011, 3, 1'b0, 1'b0, 1'b0);
        cur_tag = "R11";
        run_read(1'b0, 10'h07E, 2, 1'b1, 1'b1, 1'b0);
        chk(err_nack == 1'b1, "err_nack kept after Stop (R11)", err_nack, 1);
        cur_tag = "R2";
        run_read(1'b0, 10'h035, 1, 1'b1, 1'b0, 1'b0);
        cur_tag = "R3";
        run_read(1'b1, 10'h1A4, 1, 1'b1, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL %s watchdog expired: actual=1 expected=0", cur_tag);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule